// File: doc/BRIEF.md
# Interlaced Framebuffer Scanline Fetcher

This block produces the read bursts that bring one display scanline at a time out of memory. It keeps two internal line pointers, one per framebuffer (A and B). On every line-start request it reads one scanline from the framebuffer that is currently selected, as a run of equal-sized bursts. It then steps that framebuffer's pointer forward by the line stride and, in the alternating modes, selects the other framebuffer for the next line. A start-of-frame pulse reloads both pointers from the base inputs and sets the starting framebuffer.

The interlace mode sets how the lines are interleaved:
- mode 0 reads from A only;
- mode 1 alternates between two pointers that both start at base A, so every source line is read twice;
- mode 2 alternates A, B, A, B;
- mode 3 alternates B, A, B, A.

The burst-size code sets the burst length. A code that is not supported blanks the line and reads nothing. The memory side is a plain request/acknowledge handshake. Each burst is described by an address and a word count, where a word is 8 bytes.

Top module: `fb_line_fetcher`

## Requirements
- R1: On `frameStart`, the framebuffer A pointer loads `baseA`. The framebuffer B pointer loads `baseB`, or `baseA` in mode 1. The first line after the pulse comes from A in modes 0, 1 and 2.
- R2: In mode 0 (`ilMode`=0), every line comes from A (`lineSrc`=0), and line k starts at `baseA + k*stride`.
- R3: In mode 1, `lineSrc` alternates 0, 1, 0, 1. The line start addresses run base, base, base+stride, base+stride, where base is `baseA`.
- R4: In mode 2, lines alternate A, B starting with A. The k-th line taken from each framebuffer starts at that framebuffer's base plus k*stride.
- R5: In mode 3, lines alternate B, A starting with B (`lineSrc`=1 on the first line).
- R6: Burst code 0, 1 or 2 gives `rdWords` of 4, 8 or 16. Successive bursts of a line step the address by 32, 64 or 128 bytes. A line is ceil(`lineBytes` / burst bytes) bursts.
- R7: Burst code 3 issues no request for the line and raises `blankLine` until the next line start or frame start. Pointers and framebuffer selection still advance.
- R8: When `lineBytes` is not a multiple of the burst size, `lineErr` is raised for that line and the last burst is still issued at full length.
- R9: A raised `rdReq` stays high with `rdAddr` and `rdWords` unchanged until it is acknowledged.
- R10: A `lineStart` that arrives while a line is being read is ignored.
- R11: `frameStart` aborts a line in progress, and `rdReq` is low in the following cycle.
- R12: After reset, `rdReq`, `busy`, `blankLine` and `lineErr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Start-of-frame pulse; reloads the pointers |
| lineStart | input | 1 | Request to read the next scanline |
| baseA | input | ADDR_W | Framebuffer A base byte address |
| baseB | input | ADDR_W | Framebuffer B base byte address |
| stride | input | ADDR_W | Byte distance between lines of one framebuffer |
| ilMode | input | 2 | Interlace mode: 0 A only, 1 doubled A, 2 A first, 3 B first |
| burstCode | input | 2 | Burst size: 0 = 4 words, 1 = 8 words, 2 = 16 words, 3 = blank |
| lineBytes | input | LEN_W | Scanline length in bytes |
| rdReq | output | 1 | Burst read request |
| rdAddr | output | ADDR_W | Burst byte address |
| rdWords | output | WORDS_W | Burst length in words |
| rdAck | input | 1 | Burst accepted |
| busy | output | 1 | A line is being read |
| lineSrc | output | 1 | Framebuffer of the current line (0 A, 1 B) |
| blankLine | output | 1 | Current line is blanked |
| lineErr | output | 1 | Current line width is not a multiple of the burst size |

## Verification
Each interlace mode is run over several consecutive lines, with one base, stride and width. A wrong start buffer, a missing toggle, or a pointer that skips or repeats shows up as a wrong line address or a wrong `lineSrc`. The three burst sizes are crossed with those modes, and a width that is not a multiple of the burst size is included. Together these separate errors in the burst count from errors in the address step. Blank lines are placed between normal lines, so the address of the next fetched line shows whether the pointers kept advancing. The acknowledge is held off in an irregular pattern, which exercises the hold rule. A second line request and a frame pulse are each injected in the middle of a line.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  typedef enum logic [1:0] {
    IL_A  = 2'd0,
    IL_AA = 2'd1,
    IL_AB = 2'd2,
    IL_BA = 2'd3
  } ilMode_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } fetchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFrame;
    logic startLine;
    logic advBurst;
  } fetchStrobe_t;

  localparam logic [1:0] CODE_BLANK = 2'd3;

endpackage

// File: rtl/fbf_datapath.sv
module fbf_datapath
  import fbf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 8,
  parameter int BASE_WORDS = 4,
  parameter int WORDS_W    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  fetchStrobe_t       strb,
  input  logic [ADDR_W-1:0]  baseA,
  input  logic [ADDR_W-1:0]  baseB,
  input  logic [ADDR_W-1:0]  stride,
  input  logic [1:0]         ilMode,
  input  logic [1:0]         burstCode,
  input  logic [LEN_W-1:0]   lineBytes,
  output logic [LEN_W-1:0]   lineBursts,
  output logic               lineBlank,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [WORDS_W-1:0] rdWords,
  output logic               lineSrc,
  output logic               blankLine,
  output logic               lineErr
);

  localparam int BASE_BYTES = WORD_BYTES * BASE_WORDS;
  localparam int BASE_SH    = $clog2(BASE_BYTES);

  ilMode_e mode;
  assign mode = ilMode_e'(ilMode);

  // burst arithmetic for the line about to start
  logic [LEN_W-1:0] burstBytesIn;
  logic [5:0]       shiftAmt;
  logic [LEN_W-1:0] fullBursts;
  logic             remNz;

  always_comb begin
    burstBytesIn = LEN_W'(BASE_BYTES) << burstCode;
    shiftAmt     = 6'(BASE_SH) + {4'd0, burstCode};
    fullBursts   = lineBytes >> shiftAmt;
    remNz        = |(lineBytes & (burstBytesIn - LEN_W'(1)));
    lineBursts   = fullBursts + LEN_W'(remNz);
    lineBlank    = (burstCode == CODE_BLANK);
  end

  // framebuffer selection: 0 = A, 1 = B
  logic sel;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sel <= 1'b0;
    end else if (strb.loadFrame) begin
      sel <= (mode == IL_BA);
    end else if (strb.startLine && mode != IL_A) begin
      sel <= ~sel;
    end
  end

  // one line pointer per framebuffer
  logic [ADDR_W-1:0] ptr [2];
  for (genvar fb = 0; fb < 2; fb++) begin : g_ptr
    logic [ADDR_W-1:0] ptrQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrQ <= '0;
      end else if (strb.loadFrame) begin
        ptrQ <= (fb == 0 || mode == IL_AA) ? baseA : baseB;
      end else if (strb.startLine && sel == 1'(fb)) begin
        ptrQ <= ptrQ + stride;
      end
    end
    assign ptr[fb] = ptrQ;
  end

  // per-line state
  logic [1:0]        lineCode;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] addrStep;

  assign addrStep = ADDR_W'(BASE_BYTES) << lineCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCode  <= '0;
      curAddr   <= '0;
      lineSrc   <= 1'b0;
      blankLine <= 1'b0;
      lineErr   <= 1'b0;
    end else if (strb.loadFrame) begin
      blankLine <= 1'b0;
      lineErr   <= 1'b0;
    end else if (strb.startLine) begin
      lineCode  <= burstCode;
      curAddr   <= ptr[sel];
      lineSrc   <= sel;
      blankLine <= lineBlank;
      lineErr   <= !lineBlank && remNz;
    end else if (strb.advBurst) begin
      curAddr <= curAddr + addrStep;
    end
  end

  assign rdAddr  = curAddr;
  assign rdWords = WORDS_W'(BASE_WORDS) << lineCode;

endmodule

// File: rtl/fbf_ctrl.sv
module fbf_ctrl
  import fbf_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             lineStart,
  input  logic [LEN_W-1:0] lineBursts,
  input  logic             lineBlank,
  input  logic             rdAck,
  output fetchStrobe_t     strb,
  output logic             rdReq,
  output logic             busy
);

  fetchState_e      state;
  logic [LEN_W-1:0] cnt;
  logic             goFetch;
  logic             lastAck;

  always_comb begin
    strb.loadFrame = frameStart;
    strb.startLine = lineStart && !frameStart && state == ST_IDLE;
    strb.advBurst  = state == ST_FETCH && rdAck && !frameStart;
    goFetch        = strb.startLine && !lineBlank && lineBursts != '0;
    lastAck        = strb.advBurst && cnt == LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (frameStart) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (goFetch) begin
      state <= ST_FETCH;
      cnt   <= lineBursts;
    end else if (strb.advBurst) begin
      cnt <= cnt - LEN_W'(1);
      if (lastAck) state <= ST_IDLE;
    end
  end

  assign rdReq = (state == ST_FETCH);
  assign busy  = (state == ST_FETCH);

  // checker-side accounting of accepted bursts per line
  logic [LEN_W-1:0] ackSeen;
  logic [LEN_W-1:0] burstsExp;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackSeen   <= '0;
      burstsExp <= '0;
    end else if (strb.startLine) begin
      ackSeen   <= '0;
      burstsExp <= lineBursts;
    end else if (strb.advBurst) begin
      ackSeen <= ackSeen + LEN_W'(1);
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck && !frameStart |=> rdReq);

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !rdReq && !busy);

  assert_burst_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    lastAck |-> ackSeen + LEN_W'(1) == burstsExp);

endmodule

// File: rtl/fb_line_fetcher.sv
module fb_line_fetcher
  import fbf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int WORD_BYTES = 8,
  parameter int BASE_WORDS = 4,
  localparam int WORDS_W   = $clog2(BASE_WORDS) + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               lineStart,
  input  logic [ADDR_W-1:0]  baseA,
  input  logic [ADDR_W-1:0]  baseB,
  input  logic [ADDR_W-1:0]  stride,
  input  logic [1:0]         ilMode,
  input  logic [1:0]         burstCode,
  input  logic [LEN_W-1:0]   lineBytes,
  output logic               rdReq,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [WORDS_W-1:0] rdWords,
  input  logic               rdAck,
  output logic               busy,
  output logic               lineSrc,
  output logic               blankLine,
  output logic               lineErr
);

  fetchStrobe_t     strb;
  logic [LEN_W-1:0] lineBursts;
  logic             lineBlank;

  fbf_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .lineStart  (lineStart),
    .lineBursts (lineBursts),
    .lineBlank  (lineBlank),
    .rdAck      (rdAck),
    .strb       (strb),
    .rdReq      (rdReq),
    .busy       (busy)
  );

  fbf_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .WORD_BYTES (WORD_BYTES),
    .BASE_WORDS (BASE_WORDS),
    .WORDS_W    (WORDS_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .baseA      (baseA),
    .baseB      (baseB),
    .stride     (stride),
    .ilMode     (ilMode),
    .burstCode  (burstCode),
    .lineBytes  (lineBytes),
    .lineBursts (lineBursts),
    .lineBlank  (lineBlank),
    .rdAddr     (rdAddr),
    .rdWords    (rdWords),
    .lineSrc    (lineSrc),
    .blankLine  (blankLine),
    .lineErr    (lineErr)
  );

  assert_blank_no_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    blankLine |-> !rdReq);

  assert_ignore_busy_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy && lineStart && !frameStart |=> $stable(lineSrc) && $stable(lineErr));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck && !frameStart |=> $stable(rdAddr) && $stable(rdWords));

endmodule

// File: tb/sim_fb_line_fetcher.sv
module sim_fb_line_fetcher;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        lineStart = 1'b0;
  logic [31:0] baseA = 32'h1000_0000;
  logic [31:0] baseB = 32'h2000_0000;
  logic [31:0] stride = 32'h300;
  logic [1:0]  ilMode = 2'd0;
  logic [1:0]  burstCode = 2'd0;
  logic [15:0] lineBytes = 16'd384;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic [4:0]  rdWords;
  logic        rdAck = 1'b0;
  logic        busy, lineSrc, blankLine, lineErr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // expected bursts
  logic [31:0] expAddr[$];
  logic [31:0] expWords[$];

  // reference pointers
  logic [31:0] mA, mB;
  logic        mSel;

  // R9 tracking
  logic        heldPrev = 1'b0;
  logic [31:0] heldAddr;

  always #4 clk = ~clk;

  fb_line_fetcher u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .baseA(baseA), .baseB(baseB), .stride(stride), .ilMode(ilMode),
    .burstCode(burstCode), .lineBytes(lineBytes), .rdReq(rdReq),
    .rdAddr(rdAddr), .rdWords(rdWords), .rdAck(rdAck), .busy(busy),
    .lineSrc(lineSrc), .blankLine(blankLine), .lineErr(lineErr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor and acknowledge driver
  always @(negedge clk) begin
    cyc++;
    rdAck = rstN && rdReq && ((cyc % 3) != 1);
    if (rdReq && heldPrev) chk("R9 address held", rdAddr, heldAddr);
    heldPrev = rdReq && !rdAck;
    heldAddr = rdAddr;
    if (rdReq && rdAck) begin
      if (expAddr.size() == 0) begin
        chk("R6 unexpected burst", rdAddr, 32'hffff_ffff);
      end else begin
        chk("R6 burst address", rdAddr, expAddr.pop_front());
        chk("R6 burst words", 32'(rdWords), expWords.pop_front());
      end
    end
  end

  task automatic modelFrame();
    mA   = baseA;
    mB   = (ilMode == 2'd1) ? baseA : baseB;
    mSel = (ilMode == 2'd3);
  endtask

  task automatic doFrame();
    @(negedge clk) frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    expAddr.delete();
    expWords.delete();
    modelFrame();
  endtask

  task automatic runLine(string req, bit poke, bit abort);
    int unsigned bb, n;
    logic [31:0] a;
    bit expSrc, expBlank, expErr;
    bb       = 32 << burstCode;
    expBlank = (burstCode == 2'd3);
    expErr   = !expBlank && (lineBytes % bb != 0);
    expSrc   = mSel;
    a        = mSel ? mB : mA;
    if (!expBlank) begin
      n = (lineBytes + bb - 1) / bb;
      for (int i = 0; i < int'(n); i++) begin
        expAddr.push_back(a + 32'(i) * bb);
        expWords.push_back(32'(4 << burstCode));
      end
    end
    if (mSel) mB = mB + stride; else mA = mA + stride;
    if (ilMode != 2'd0) mSel = !mSel;
    @(negedge clk) lineStart = 1'b1;
    @(negedge clk) lineStart = 1'b0;
    if (abort) begin
      repeat (3) @(negedge clk);
      frameStart = 1'b1;
      @(negedge clk) frameStart = 1'b0;
      chk("R11 request dropped", 32'(rdReq), 0);
      chk("R11 idle after abort", 32'(busy), 0);
      expAddr.delete();
      expWords.delete();
      modelFrame();
      return;
    end
    if (poke) begin
      repeat (2) @(negedge clk);
      chk("R10 busy before extra start", 32'(busy), 1);
      lineStart = 1'b1;
      @(negedge clk) lineStart = 1'b0;
    end
    while (busy) @(negedge clk);
    chk({req, " bursts drained"}, 32'(expAddr.size()), 0);
    chk({req, " line source"}, 32'(lineSrc), 32'(expSrc));
    chk({req, " R7 blank flag"}, 32'(blankLine), 32'(expBlank));
    chk({req, " R8 error flag"}, 32'(lineErr), 32'(expErr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 rdReq", 32'(rdReq), 0);
    chk("R12 busy", 32'(busy), 0);
    chk("R12 blankLine", 32'(blankLine), 0);
    chk("R12 lineErr", 32'(lineErr), 0);
    rstN = 1'b1;

    // R2, R1: mode 0, 4-word bursts
    ilMode = 2'd0; burstCode = 2'd0;
    doFrame();
    for (int i = 0; i < 3; i++) runLine("R2 R1", 0, 0);

    // R3: mode 1, 8-word bursts
    ilMode = 2'd1; burstCode = 2'd1;
    doFrame();
    for (int i = 0; i < 4; i++) runLine("R3", 0, 0);

    // R4: mode 2, 16-word bursts
    ilMode = 2'd2; burstCode = 2'd2;
    doFrame();
    for (int i = 0; i < 4; i++) runLine("R4", 0, 0);

    // R5: mode 3
    ilMode = 2'd3; burstCode = 2'd0;
    doFrame();
    for (int i = 0; i < 3; i++) runLine("R5", 0, 0);

    // R7: blank lines still advance pointers
    ilMode = 2'd2; burstCode = 2'd3;
    doFrame();
    runLine("R7", 0, 0);
    runLine("R7", 0, 0);
    burstCode = 2'd2;
    runLine("R7 after blank", 0, 0);
    runLine("R7 after blank", 0, 0);

    // R8: width not a multiple of burst size
    burstCode = 2'd1; lineBytes = 16'd400;
    runLine("R8", 0, 0);
    lineBytes = 16'd384;
    runLine("R8 clear", 0, 0);

    // R10: extra start while busy
    burstCode = 2'd0;
    runLine("R10", 1, 0);
    runLine("R10 next", 0, 0);

    // R11: abort by frame pulse
    runLine("R11", 0, 1);
    runLine("R11 restart", 0, 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule